// File: doc/BRIEF.md
# Parallel Strided Bank Address Generator

This block feeds an eight-bank, low-order-interleaved memory that a vector unit reads in parallel. A command gives a starting row, an odd stride, a run length counted in parallel accesses, and an index term. After the command is taken, the block produces eight row addresses every cycle, one per bank, so that eight consecutive elements of the strided vector can be fetched in one cycle. Any odd stride is coprime with eight, so the eight elements of one access always land in eight different banks.

No crossbar routes element addresses to banks. Each bank forms its own row from three parts. The first is a shared running term that starts at the base row and grows by the stride on every access. The second is the index term. The third is a small row offset for that bank, which a combinational decoder derives from the stride. The datapath has three register stages: the running accumulator, the merge with the index, and the per-bank addition. A length counter ends the run, and a one-cycle done pulse follows the last valid set of addresses.

Top module: `bankAddrGen`

## Requirements
- R1: After reset `busyO`, `validO` and `doneO` are all low.
- R2: Bits [2:0] of the stride code field select the stride S = 2·code+1, which covers the odd values 1 to 15. Bit 3 of the field has no effect on any address.
- R3: In the first valid set of a run, lane j of `rowAddrO` (bits 32·j+31 down to 32·j) equals base + index + (e·S) div 8. Here e in 0..7 is the element for which (e·S) mod 8 = j.
- R4: Each valid set after the first in a run is the previous set with S added to every lane.
- R5: A run of length L > 0 holds `validO` high for exactly L consecutive cycles. `validO` first goes high on the third rising edge after the edge that samples `startI`.
- R6: `doneO` is high for exactly one cycle, the cycle right after the last valid set, and never while `validO` is high.
- R7: A command of length 0 produces no valid set. `doneO` goes high in the cycle right after the edge that samples `startI`.
- R8: The command inputs are captured only at the accepted start. A start or input change during a run has no effect on that run's addresses or length.
- R9: `busyO` is high from the accepting edge through the done cycle. A start sampled during the done cycle is ignored. A start in the following cycle is accepted.
- R10: Address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| startI | input | 1 | Command strobe, taken only while idle |
| baseRowI | input | 32 | Row of the first element |
| strideCodeI | input | 4 | Stride code: bits [2:0] give S = 2·code+1, bit 3 unused |
| lengthI | input | 16 | Number of parallel access cycles |
| indexI | input | 32 | Index term added to every row |
| busyO | output | 1 | A command is in progress |
| validO | output | 1 | `rowAddrO` holds a valid set |
| rowAddrO | output | 256 | Eight 32-bit bank rows, lane j in bits 32·j+31:32·j |
| doneO | output | 1 | One-cycle pulse after the last valid set |

## Verification
The hardest state to reach is the boundary between runs, where a start arrives in the done cycle itself. That start must be dropped, and the very next start must still be taken. The bench raises `startI` on the exact cycle it sees `doneO`, confirms that `busyO` stays low afterwards, and then issues a fresh command one cycle later. It also pulses start with altered inputs in the middle of a run, and changes the inputs right after each accepted start, so that any late capture shows up in the addresses. Expected rows come from walking the elements of each access and placing each one by position, not by computing bank offsets.

// File: rtl/bankAddrGenPkg.sv
package bankAddrGenPkg;
  // Strobes from the sequencer to the address datapath
  typedef struct packed {
    logic load;   // capture command fields
    logic issue;  // advance the base-stride accumulator
    logic first;  // this issue is access k = 0
    logic adv2;   // stage-1 result is valid, move to stage 2
    logic adv3;   // stage-2 result is valid, move to output stage
  } agenStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } agenState_e;
endpackage

// File: rtl/strideOffsetDecoder.sv
module strideOffsetDecoder #(
  parameter int NUM_BANKS = 8,
  parameter int CODE_W    = 3
) (
  input  logic [CODE_W-1:0]                   codeI,
  output logic [NUM_BANKS-1:0][CODE_W:0]      offsetsO
);
  localparam int STR_W  = CODE_W + 1;
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int PROD_W = STR_W + BANK_W;

  logic [STR_W-1:0] strideVal;
  assign strideVal = {codeI, 1'b1};

  // For each bank, find the element slot e whose position e*S lands there;
  // the bank's row offset is the row part of that position.
  always_comb begin
    for (int j = 0; j < NUM_BANKS; j++) begin
      offsetsO[j] = '0;
      for (int e = 0; e < NUM_BANKS; e++) begin
        logic [PROD_W-1:0] pos;
        pos = PROD_W'(e) * PROD_W'(strideVal);
        if (pos[BANK_W-1:0] == BANK_W'(j)) begin
          offsetsO[j] = pos[BANK_W +: STR_W];
        end
      end
    end
  end

  // R3: lane 0 always holds element 0 of the access, so its offset is zero
  always_comb begin
    bank0_zero_chk: assert (offsetsO[0] == '0);
  end
endmodule

// File: rtl/agenCtrl.sv
module agenCtrl
  import bankAddrGenPkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [LEN_W-1:0] lengthI,
  output agenStrobes_t     strobesO,
  output logic             busyO,
  output logic             validO,
  output logic             doneO
);
  localparam int PIPE_D = 3;

  agenState_e       state;
  logic [LEN_W-1:0] remCnt;
  logic             firstR;
  logic [PIPE_D-1:0] vPipe;
  logic             pipeEmpty;

  assign pipeEmpty       = (vPipe == '0);
  assign strobesO.load   = (state == ST_IDLE) && startI;
  assign strobesO.issue  = (state == ST_RUN);
  assign strobesO.first  = firstR;
  assign strobesO.adv2   = vPipe[0];
  assign strobesO.adv3   = vPipe[1];

  assign busyO  = (state != ST_IDLE);
  assign validO = vPipe[PIPE_D-1];
  assign doneO  = (state == ST_FLUSH) && pipeEmpty;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      remCnt <= '0;
      firstR <= 1'b0;
      vPipe  <= '0;
    end else begin
      vPipe <= {vPipe[PIPE_D-2:0], strobesO.issue};
      unique case (state)
        ST_IDLE: begin
          if (startI) begin
            remCnt <= lengthI;
            firstR <= 1'b1;
            state  <= (lengthI == '0) ? ST_FLUSH : ST_RUN;
          end
        end
        ST_RUN: begin
          remCnt <= remCnt - 1'b1;
          firstR <= 1'b0;
          if (remCnt == LEN_W'(1)) state <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (pipeEmpty) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    validO |-> busyO);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);
  // R6
  done_not_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !validO);
  // R7
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobesO.load && lengthI == '0) |=> doneO);
  // R8
  no_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && startI && !doneO) |=> busyO);
endmodule

// File: rtl/agenDatapath.sv
module agenDatapath
  import bankAddrGenPkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 32,
  parameter int CODE_W    = 3,
  parameter int FIELD_W   = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  agenStrobes_t                      strobesI,
  input  logic [ADDR_W-1:0]                 baseRowI,
  input  logic [FIELD_W-1:0]                strideCodeI,
  input  logic [ADDR_W-1:0]                 indexI,
  output logic [NUM_BANKS*ADDR_W-1:0]       rowAddrO
);
  localparam int STR_W = CODE_W + 1;

  logic [ADDR_W-1:0]  baseR, indexR, accR, sumR;
  logic [CODE_W-1:0]  codeR;
  logic [ADDR_W-1:0]  strideExt;
  logic [NUM_BANKS-1:0][STR_W-1:0]  bankOff;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] rowR;

  assign strideExt = ADDR_W'({codeR, 1'b1});

  strideOffsetDecoder #(
    .NUM_BANKS (NUM_BANKS),
    .CODE_W    (CODE_W)
  ) offDec_i (
    .codeI    (codeR),
    .offsetsO (bankOff)
  );

  // Command capture; the unused top bit of the stride field is dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR  <= '0;
      indexR <= '0;
      codeR  <= '0;
    end else if (strobesI.load) begin
      baseR  <= baseRowI;
      indexR <= indexI;
      codeR  <= strideCodeI[CODE_W-1:0];
    end
  end

  // Stages 1 and 2: running base-stride term, then merge with index
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
      sumR <= '0;
    end else begin
      if (strobesI.issue) accR <= strobesI.first ? baseR : accR + strideExt;
      if (strobesI.adv2)  sumR <= accR + indexR;
    end
  end

  // Stage 3: per-bank offset addition
  generate
    for (genvar j = 0; j < NUM_BANKS; j++) begin : g_lane
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               rowR[j] <= '0;
        else if (strobesI.adv3)  rowR[j] <= sumR + ADDR_W'(bankOff[j]);
      end
      assign rowAddrO[j*ADDR_W +: ADDR_W] = rowR[j];
    end
  endgenerate

  // R4: back-to-back output updates within a run step every lane by the stride
  stride_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobesI.adv3) && $past(strobesI.adv3, 2))
      |-> (rowR[NUM_BANKS-1] == $past(rowR[NUM_BANKS-1]) + strideExt));
endmodule

// File: rtl/bankAddrGen.sv
module bankAddrGen
  import bankAddrGenPkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int FIELD_W   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startI,
  input  logic [ADDR_W-1:0]           baseRowI,
  input  logic [FIELD_W-1:0]          strideCodeI,
  input  logic [LEN_W-1:0]            lengthI,
  input  logic [ADDR_W-1:0]           indexI,
  output logic                        busyO,
  output logic                        validO,
  output logic [NUM_BANKS*ADDR_W-1:0] rowAddrO,
  output logic                        doneO
);
  localparam int CODE_W = FIELD_W - 1;

  agenStrobes_t strobes;

  agenCtrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .lengthI  (lengthI),
    .strobesO (strobes),
    .busyO    (busyO),
    .validO   (validO),
    .doneO    (doneO)
  );

  agenDatapath #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .CODE_W    (CODE_W),
    .FIELD_W   (FIELD_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobesI    (strobes),
    .baseRowI    (baseRowI),
    .strideCodeI (strideCodeI),
    .indexI      (indexI),
    .rowAddrO    (rowAddrO)
  );
endmodule

// File: tb/bankAddrGen_tb_top.sv
module bankAddrGen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startI = 1'b0;
  logic [31:0]  baseRowI = '0;
  logic [3:0]   strideCodeI = '0;
  logic [15:0]  lengthI = '0;
  logic [31:0]  indexI = '0;
  logic         busyO, validO, doneO;
  logic [255:0] rowAddrO;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bankAddrGen dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .baseRowI(baseRowI),
    .strideCodeI(strideCodeI), .lengthI(lengthI), .indexI(indexI),
    .busyO(busyO), .validO(validO), .rowAddrO(rowAddrO), .doneO(doneO)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Place each element of access k by its position and return the row for a bank
  function automatic logic [31:0] expRow(input logic [31:0] base, input int s,
      input logic [31:0] idx, input int k, input int bank);
    logic [31:0] r = '0;
    for (int e = 0; e < 8; e++) begin
      int pos = e * s;
      if (pos % 8 == bank) r = base + 32'(k * s) + idx + 32'(pos / 8);
    end
    return r;
  endfunction

  // glitchAt > 0: pulse start mid-run; glitchAt < 0: pulse start in the done cycle
  task automatic runCmd(input logic [31:0] base, input logic [3:0] code,
      input int len, input logic [31:0] idx, input int glitchAt, input string tag);
    int s = 2 * int'(code[2:0]) + 1;
    int i = 0, k = 0, firstV = -1, doneAt = -1;
    @(negedge clk);
    startI = 1'b1; baseRowI = base; strideCodeI = code;
    lengthI = 16'(len); indexI = idx;
    while (doneAt < 0 && i < len + 20) begin
      @(negedge clk);
      i++;
      if (i == 1) chk(busyO == 1'b1, {"R9 busy after start ", tag}, 32'(busyO), 1);
      if (validO) begin
        if (firstV < 0) firstV = i;
        for (int b = 0; b < 8; b++)
          chk(rowAddrO[b*32 +: 32] == expRow(base, s, idx, k, b),
              (k == 0) ? {"R3 first set ", tag} : {"R4 stepped set ", tag},
              rowAddrO[b*32 +: 32], expRow(base, s, idx, k, b));
        k++;
      end
      if (doneO) doneAt = i;
      // change the inputs after acceptance to expose late capture (R8)
      baseRowI = ~base; strideCodeI = code ^ 4'h5; lengthI = 16'(len + 3);
      indexI = idx + 32'h77;
      startI = ((glitchAt > 0 && i == glitchAt) || (glitchAt < 0 && doneO)) ? 1'b1 : 1'b0;
    end
    if (len > 0) chk(firstV == 4, {"R5 first valid cycle ", tag}, 32'(firstV), 4);
    chk(k == len, {"R5 valid count ", tag}, 32'(k), 32'(len));
    chk(doneAt == ((len == 0) ? 1 : 4 + len),
        (len == 0) ? {"R7 done timing ", tag} : {"R6 done timing ", tag},
        32'(doneAt), 32'((len == 0) ? 1 : 4 + len));
    @(negedge clk);
    startI = 1'b0;
    chk(doneO == 1'b0, {"R6 done one cycle ", tag}, 32'(doneO), 0);
    chk(busyO == 1'b0, {"R9 idle after done ", tag}, 32'(busyO), 0);
    chk(validO == 1'b0, {"R5 no extra valid ", tag}, 32'(validO), 0);
  endtask

  task automatic testReset();
    chk(busyO == 1'b0, "R1 busy at reset", 32'(busyO), 0);
    chk(validO == 1'b0, "R1 valid at reset", 32'(validO), 0);
    chk(doneO == 1'b0, "R1 done at reset", 32'(doneO), 0);
  endtask

  task automatic testStride3();
    runCmd(32'd100, 4'd1, 4, 32'd0, 0, "stride3");
  endtask

  task automatic testAllStrides();
    for (int c = 0; c < 8; c++) runCmd(32'h1000 + 32'(c), 4'(c), 3, 32'd9, 0, "sweep R2");
  endtask

  task automatic testTopBitIgnored();
    runCmd(32'd40, 4'b1010, 2, 32'd5, 0, "R2 top bit");
  endtask

  task automatic testZeroLength();
    runCmd(32'd7, 4'd3, 0, 32'd0, 0, "R7 zero length");
  endtask

  task automatic testMidRunStart();
    runCmd(32'd500, 4'd5, 6, 32'd16, 3, "R8 mid-run start");
  endtask

  task automatic testWrap();
    runCmd(32'hFFFF_FFF0, 4'd7, 3, 32'd4, 0, "R10 wrap");
  endtask

  task automatic testDoneCycleStart();
    runCmd(32'd64, 4'd2, 2, 32'd0, -1, "R9 start in done cycle");
    runCmd(32'd200, 4'd6, 1, 32'd300, 0, "R9 back to back single word");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStride3();
    testAllStrides();
    testTopBitIgnored();
    testZeroLength();
    testMidRunStart();
    testWrap();
    testDoneCycleStart();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule